// File: doc/BRIEF.md
# Banked 24-bit Address Generator

This unit turns a 16-bit offset into a 24-bit bus address for a 16-bit accumulator processor of the classic 8-bit family. It holds four pieces of addressing state: a code bank, a data bank, a relocatable direct-page base and a 16-bit stack pointer. Each request names an access kind: instruction fetch, data, stack or direct. It also gives an offset and, optionally, an index. One clock later the unit presents the address.

The state changes only through a small load command port that stands for the instructions writing these registers. A compatibility input selects the legacy 8-bit model. In that model, indices shrink to their low byte and the stack is confined to page one of bank zero. Instruction decode, arithmetic and bus timing are outside this unit.

Top module: `bank_addr_gen`

## Requirements
- R1: A fetch request (req_kind 0) yields address {code bank, req_offset}. The index is never added, even when req_use_index is 1.
- R2: A data request (req_kind 1) yields ({data bank, 16'h0000} + req_offset + effective index) modulo 2^24. A carry past $FFFF therefore increments bits 23:16.
- R3: Reset sets code bank, data bank and direct base to 0 and the stack pointer to $01FF. A register changes only through its own load command. Requests and loads of the other registers leave it unchanged.
- R4: In native mode (emu_mode 0) with req_use_index 1, the effective index is the full 16-bit req_index. With req_use_index 0, the effective index is zero.
- R5: A native stack request (req_kind 2) yields {8'h00, (stack pointer + req_offset) mod 2^16}.
- R6: A direct request (req_kind 3) yields {8'h00, (direct base + req_offset[7:0] + effective index) mod 2^16}. Bits 15:8 of req_offset are ignored.
- R7: With emu_mode 1, the effective index is {8'h00, req_index[7:0]}. A stack request yields {8'h00, 8'h01, (stack pointer[7:0] + req_offset[7:0]) mod 256}.
- R8: addr_valid is 1 exactly in the cycle after a cycle with req_valid 1. addr then carries that request's address. Reset clears addr_valid and addr.
- R9: cmd_op encodings are 0 none, 1 load code bank from cmd_data[7:0], 2 load data bank from cmd_data[7:0], 3 load direct base, and 4 load stack pointer. A request in the same cycle as a load uses the old value. Later requests use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| emu_mode | input | 1 | 1 selects the legacy 8-bit addressing model |
| cmd_op | input | 3 | Register load command |
| cmd_data | input | 16 | Load value |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | 0 fetch, 1 data, 2 stack, 3 direct |
| req_offset | input | 16 | Offset or operand |
| req_index | input | 16 | Index value |
| req_use_index | input | 1 | Add the index (data and direct only) |
| addr_valid | output | 1 | Address valid, one cycle after the request |
| addr | output | 24 | 24-bit bus address |

## Verification
The bench goes after several boundary cases. One is a data offset near $FFFF plus an index: a design that drops the carry stays in the old bank. Another is a direct base near $FFFF: a design that does not wrap there leaks into bank one. The bench also sends indices above $FF, which separates a truncating design in native mode from a non-truncating one in legacy mode. It checks the stack-pointer low byte wrapping in legacy mode, where a wrong design crosses out of page one. It checks a fetch that carries an index, which must not be added. Finally, it issues a load and a request in the same cycle, which exposes a design that forwards the new bank value too early.

// File: rtl/bag_pkg.sv
package bag_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH  = 2'd0,
      ACC_DATA   = 2'd1,
      ACC_STACK  = 2'd2,
      ACC_DIRECT = 2'd3
   } acc_kind_e;

   typedef enum logic [2:0] {
      LD_NONE  = 3'd0,
      LD_PBANK = 3'd1,
      LD_DBANK = 3'd2,
      LD_DPAGE = 3'd3,
      LD_SPTR  = 3'd4
   } ld_op_e;
endpackage

// File: rtl/bag_regs.sv
module bag_regs
   import bag_pkg::*;
#(
   parameter int OFF_W = 16,
   parameter int BANK_W = 8,
   parameter logic [OFF_W-1:0] SP_INIT = 16'h01FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        ld_op,
   input  logic [OFF_W-1:0]  ld_data,
   output logic [BANK_W-1:0] pbank,
   output logic [BANK_W-1:0] dbank,
   output logic [OFF_W-1:0]  dpage,
   output logic [OFF_W-1:0]  sptr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pbank <= '0;
         dbank <= '0;
         dpage <= '0;
         sptr  <= SP_INIT;
      end else begin
         case (ld_op_e'(ld_op))
            LD_PBANK: pbank <= ld_data[BANK_W-1:0];
            LD_DBANK: dbank <= ld_data[BANK_W-1:0];
            LD_DPAGE: dpage <= ld_data;
            LD_SPTR:  sptr  <= ld_data;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/bag_calc.sv
module bag_calc
   import bag_pkg::*;
#(
   parameter int OFF_W = 16,
   parameter int BANK_W = 8,
   parameter int DIR_W = 8,
   localparam int ADDR_W = OFF_W + BANK_W
) (
   input  logic [1:0]        kind,
   input  logic [OFF_W-1:0]  offset,
   input  logic [OFF_W-1:0]  index,
   input  logic              use_index,
   input  logic              emu,
   input  logic [BANK_W-1:0] pbank,
   input  logic [BANK_W-1:0] dbank,
   input  logic [OFF_W-1:0]  dpage,
   input  logic [OFF_W-1:0]  sptr,
   output logic [ADDR_W-1:0] addr
);
   localparam int PAD_W = OFF_W - DIR_W;

   logic [OFF_W-1:0]  idx_eff;
   logic [ADDR_W-1:0] data_sum;
   logic [OFF_W-1:0]  direct_sum;
   logic [OFF_W-1:0]  stack_native;
   logic [DIR_W-1:0]  stack_low;
   logic [OFF_W-1:0]  stack_emu;

   always_comb begin
      if (!use_index)
         idx_eff = '0;
      else if (emu)
         idx_eff = {{PAD_W{1'b0}}, index[DIR_W-1:0]};
      else
         idx_eff = index;
   end

   assign data_sum     = {dbank, {OFF_W{1'b0}}} + ADDR_W'(offset) + ADDR_W'(idx_eff);
   assign direct_sum   = dpage + OFF_W'(offset[DIR_W-1:0]) + idx_eff;
   assign stack_native = sptr + offset;
   assign stack_low    = sptr[DIR_W-1:0] + offset[DIR_W-1:0];
   assign stack_emu    = {{(PAD_W-1){1'b0}}, 1'b1, stack_low};

   always_comb begin
      case (acc_kind_e'(kind))
         ACC_FETCH:  addr = {pbank, offset};
         ACC_DATA:   addr = data_sum;
         ACC_STACK:  addr = {{BANK_W{1'b0}}, emu ? stack_emu : stack_native};
         default:    addr = {{BANK_W{1'b0}}, direct_sum};
      endcase
   end
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
   import bag_pkg::*;
#(
   parameter int OFF_W = 16,
   parameter int BANK_W = 8,
   parameter int DIR_W = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int ADDR_W = OFF_W + BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              emu_mode,
   input  logic [2:0]        cmd_op,
   input  logic [OFF_W-1:0]  cmd_data,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic [OFF_W-1:0]  req_index,
   input  logic              req_use_index,
   output logic              addr_valid,
   output logic [ADDR_W-1:0] addr
);
   if (OFF_W <= DIR_W + 1) begin : g_bad_off
      $error("bank_addr_gen: OFF_W must exceed DIR_W + 1");
   end
   if (BANK_W > OFF_W) begin : g_bad_bank
      $error("bank_addr_gen: BANK_W must not exceed OFF_W");
   end

   logic [BANK_W-1:0] pbank;
   logic [BANK_W-1:0] dbank;
   logic [OFF_W-1:0]  dpage;
   logic [OFF_W-1:0]  sptr;
   logic [ADDR_W-1:0] addr_next;

   bag_regs #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .ld_op(cmd_op), .ld_data(cmd_data),
      .pbank(pbank), .dbank(dbank), .dpage(dpage), .sptr(sptr)
   );

   bag_calc #(.OFF_W(OFF_W), .BANK_W(BANK_W), .DIR_W(DIR_W)) u_calc (
      .kind(req_kind), .offset(req_offset), .index(req_index),
      .use_index(req_use_index), .emu(emu_mode),
      .pbank(pbank), .dbank(dbank), .dpage(dpage), .sptr(sptr),
      .addr(addr_next)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_valid <= 1'b0;
            addr       <= '0;
         end else begin
            addr_valid <= req_valid;
            if (req_valid) addr <= addr_next;
         end
      end
   end else begin : g_comb_out
      assign addr_valid = req_valid;
      assign addr       = addr_next;
   end
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
   parameter int OFF_W = 16,
   parameter int BANK_W = 8,
   localparam int ADDR_W = OFF_W + BANK_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              emu_mode,
   input logic [2:0]        cmd_op,
   input logic              req_valid,
   input logic [1:0]        req_kind,
   input logic [OFF_W-1:0]  req_offset,
   input logic              req_use_index,
   input logic              addr_valid,
   input logic [ADDR_W-1:0] addr,
   input logic [BANK_W-1:0] pbank,
   input logic [BANK_W-1:0] dbank
);
   AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == 2'd0 |=> addr == {$past(pbank), $past(req_offset)}); // R1
   AST_DATA_NOIDX: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == 2'd1 && !req_use_index |=> addr == {$past(dbank), $past(req_offset)}); // R2
   AST_DBANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_op != 3'd2 |=> $stable(dbank)); // R3
   AST_PBANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_op != 3'd1 |=> $stable(pbank)); // R3
   AST_STACK_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == 2'd2 |=> addr[ADDR_W-1:OFF_W] == '0); // R5
   AST_DIRECT_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == 2'd3 |=> addr[ADDR_W-1:OFF_W] == '0); // R6
   AST_EMU_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == 2'd2 && emu_mode |=> addr[OFF_W-1:8] == 8'h01); // R7
   AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> addr_valid); // R8
   AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !addr_valid); // R8
endmodule

bind bank_addr_gen bag_checker #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .cmd_op(cmd_op),
   .req_valid(req_valid), .req_kind(req_kind), .req_offset(req_offset),
   .req_use_index(req_use_index), .addr_valid(addr_valid), .addr(addr),
   .pbank(pbank), .dbank(dbank)
);

// File: tb/bank_addr_gen_bench.sv
`timescale 1ns/1ps
module bank_addr_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        emu_mode = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [15:0] cmd_data = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [15:0] req_offset = '0;
   logic [15:0] req_index = '0;
   logic        req_use_index = 1'b0;
   logic        addr_valid;
   logic [23:0] addr;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   logic [7:0]  m_pb, m_db;
   logic [15:0] m_dp, m_sp;
   logic        m_emu;

   logic [23:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   bank_addr_gen u_bank_addr_gen (
      .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .req_valid(req_valid), .req_kind(req_kind),
      .req_offset(req_offset), .req_index(req_index),
      .req_use_index(req_use_index), .addr_valid(addr_valid), .addr(addr)
   );

   task automatic check(string req, logic [23:0] act, logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %06h expected %06h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] model(logic [1:0] k, logic [15:0] off,
                                         logic [15:0] idx, logic use_i);
      logic [15:0] ie;
      logic [7:0]  lo;
      ie = !use_i ? 16'h0 : (m_emu ? {8'h00, idx[7:0]} : idx);
      case (k)
         2'd0: return {m_pb, off};
         2'd1: return {m_db, 16'h0} + {8'h00, off} + {8'h00, ie};
         2'd2: begin
            lo = m_sp[7:0] + off[7:0];
            return m_emu ? {16'h0001, lo} : {8'h00, m_sp + off};
         end
         default: return {8'h00, m_dp + {8'h00, off[7:0]} + ie};
      endcase
   endfunction

   task automatic apply_load(logic [2:0] op, logic [15:0] d);
      cmd_op = op;
      cmd_data = d;
      case (op)
         3'd1: m_pb = d[7:0];
         3'd2: m_db = d[7:0];
         3'd3: m_dp = d;
         3'd4: m_sp = d;
         default: ;
      endcase
   endtask

   task automatic load(logic [2:0] op, logic [15:0] d);
      @(negedge clk);
      req_valid = 1'b0;
      apply_load(op, d);
   endtask

   task automatic issue(logic [1:0] k, logic [15:0] off, logic [15:0] idx,
                        logic use_i, string tag, logic [2:0] op = 3'd0,
                        logic [15:0] d = 16'h0);
      @(negedge clk);
      exp_q.push_back(model(k, off, idx, use_i));
      tag_q.push_back(tag);
      req_valid = 1'b1;
      req_kind = k;
      req_offset = off;
      req_index = idx;
      req_use_index = use_i;
      cmd_op = 3'd0;
      if (op != 3'd0) apply_load(op, d);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
      cmd_op = 3'd0;
   endtask

   task automatic set_emu(logic e);
      @(negedge clk);
      req_valid = 1'b0;
      cmd_op = 3'd0;
      emu_mode = e;
      m_emu = e;
   endtask

   // monitor: pops expected addresses as results appear
   always @(negedge clk) begin
      if (rst_n && addr_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R8: actual valid=1 expected valid=0 (no request pending)");
         end else begin
            check(tag_q.pop_front(), addr, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      m_pb = 8'h00; m_db = 8'h00; m_dp = 16'h0000; m_sp = 16'h01FF; m_emu = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 reset addr", addr, 24'h0);
      check("R8 reset valid", {23'h0, addr_valid}, 24'h0);
      rst_n = 1'b1;
      // R3 reset values observed through the ports
      issue(2'd0, 16'h0100, 16'h0, 1'b0, "R3 reset code bank");
      issue(2'd1, 16'h0200, 16'h0, 1'b0, "R3 reset data bank");
      issue(2'd2, 16'h0000, 16'h0, 1'b0, "R3 reset stack pointer");
      issue(2'd3, 16'h0010, 16'h0, 1'b0, "R3 reset direct base");
      // R9 loads
      load(3'd1, 16'h0012);
      load(3'd2, 16'h0034);
      load(3'd3, 16'h2000);
      load(3'd4, 16'h7F00);
      issue(2'd0, 16'hABCD, 16'h1111, 1'b1, "R1 fetch ignores index");
      issue(2'd1, 16'h1000, 16'h0345, 1'b0, "R4 index disabled");
      issue(2'd1, 16'h1000, 16'h0345, 1'b1, "R4 full 16-bit index");
      issue(2'd1, 16'hFFF0, 16'h0020, 1'b1, "R2 carry into bank");
      issue(2'd1, 16'hFFFF, 16'h0000, 1'b0, "R2 no carry at top");
      issue(2'd2, 16'h0003, 16'h0, 1'b0, "R5 native stack");
      issue(2'd3, 16'hFF10, 16'h0005, 1'b1, "R6 direct ignores offset high byte");
      load(3'd3, 16'hFFF0);
      issue(2'd3, 16'h0020, 16'h0, 1'b0, "R6 direct wraps in bank 0");
      load(3'd4, 16'hFFFE);
      issue(2'd2, 16'h0005, 16'h0, 1'b0, "R5 stack wraps in bank 0");
      issue(2'd1, 16'h0000, 16'h0, 1'b0, "R3 data bank kept after other loads");
      // R9 same-cycle load uses old value, next request the new one
      issue(2'd1, 16'h0042, 16'h0, 1'b0, "R9 same-cycle load old bank", 3'd2, 16'h0056);
      issue(2'd1, 16'h0042, 16'h0, 1'b0, "R9 new bank after load");
      issue(2'd0, 16'h0000, 16'h0, 1'b0, "R9 code bank same cycle", 3'd1, 16'h0099);
      issue(2'd0, 16'h0000, 16'h0, 1'b0, "R9 code bank after load");
      // R7 legacy mode
      set_emu(1'b1);
      issue(2'd1, 16'h1000, 16'h0345, 1'b1, "R7 index truncated");
      issue(2'd2, 16'h0003, 16'h0, 1'b0, "R7 stack page one");
      load(3'd4, 16'h12FE);
      issue(2'd2, 16'h0005, 16'h0, 1'b0, "R7 stack low byte wraps");
      issue(2'd3, 16'h0001, 16'h1234, 1'b1, "R7 direct index truncated");
      set_emu(1'b0);
      issue(2'd2, 16'h0005, 16'h0, 1'b0, "R5 native stack after legacy");
      issue(2'd3, 16'h0001, 16'h1234, 1'b1, "R4 direct full index");
      idle();
      idle();
      check("R8 valid low when idle", {23'h0, addr_valid}, 24'h0);
      check("R8 all results seen", 24'(exp_q.size()), 24'h0);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule